// File: doc/BRIEF.md
# Key list hash message packer

This block builds the message that a repeater's key-list integrity hash is computed over, and delivers it to a hash engine one 32-bit word at a time. After a start pulse it takes in a stream of 40-bit device keys, one per downstream device. It then adds a 16-bit topology status word and a 64-bit secret value. It closes the message with zero fill and a bit-length word, so that the message ends exactly on a 64-byte block boundary.

Keys are five bytes long and output words are four bytes long. Key bytes therefore straddle word boundaries. The status and secret bytes carry on from whatever alignment the last key left behind. Every byte sits big-endian in its word, and the first byte of the message occupies bits 31:24. Both the key input and the word output use valid/ready handshaking. The block raises a last flag on the length word, pulses done after it, and rejects a device count of zero.

Top module: `keylist_hash_packer`

## Requirements
- R1: The message is every key's five bytes (bits 39:32 of a key first), then the status bytes (bits 15:8 first), then the secret bytes (bits 63:56 first). Message byte k goes into output word k/4, at bits 31:24 when k mod 4 is 0, down to bits 7:0 when k mod 4 is 3.
- R2: Key bytes that overflow a word carry into the next word. The status and secret bytes continue from the leftover alignment (0 to 3 bytes), so they may be split across two words.
- R3: When the message length 5n+10 is not a multiple of four, the unused low bytes of its final data word are zero.
- R4: After the data words, zero words are emitted until the byte offset modulo 64 equals 60. The length word then fills offset 60, so the total number of words is a multiple of 16.
- R5: The final word carries the message length in bits, (5n+10)*8, right-aligned.
- R6: word_last is high on the length word and on no other word.
- R7: While word_valid is high and word_ready is low, word_valid stays high and word_data and word_last do not change.
- R8: done is high for exactly one cycle, the cycle after the length word is accepted. The block is then idle (key_ready and word_valid low) and accepts a new start. After reset, word_valid, key_ready, done and err are all low.
- R9: A start with dev_count of 0 raises err for exactly one cycle, in the cycle after the start. No word is produced and no key is requested.
- R10: A start pulse arriving while a message is in progress is ignored, and the current message is unaffected.
- R11: Exactly dev_count keys are accepted per message. key_ready is never high after the last one is taken.
- R12: Every count from 1 to 127 is handled, including counts whose message spans several 64-byte blocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a message; status, secret and count are captured on this cycle |
| dev_count | input | 7 | Number of downstream device keys (1 to 127) |
| status | input | 16 | Topology status word |
| m0 | input | 64 | Secret session value appended after the status |
| key_valid | input | 1 | A key is offered on key_data |
| key_data | input | 40 | Device key, bits 39:32 is the first byte |
| key_ready | output | 1 | The block takes the offered key this cycle |
| word_valid | output | 1 | An output word is offered |
| word_data | output | 32 | Big-endian message word |
| word_last | output | 1 | Marks the length word |
| word_ready | input | 1 | The hash engine takes the word this cycle |
| done | output | 1 | One-cycle pulse after the length word is taken |
| err | output | 1 | One-cycle pulse when started with a zero count |

## Verification
The bench uses counts of 1, 2, 3 and 4 so that every leftover alignment (one, two, three and zero bytes) is covered. A packer that mishandled the carry would shift the status or secret bytes or drop a byte, which shows up as wrong words. Counts of 10 and 23 put the end of the data exactly at offset 60 and exactly at a block edge. Getting the fill test wrong there would insert a spurious block of zeros or place the length word at the wrong offset. A count of 127 spans eleven blocks. The bench applies irregular output backpressure and gaps in the key stream, and it also sends a start pulse in the middle of a message. These expose a word that changes while stalled, a key accepted beyond the count, and a second start that corrupts the running message.

// File: rtl/kpk_pkg.sv
package kpk_pkg;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_KEYS,
        PH_STAT,
        PH_SECRET,
        PH_FLUSH,
        PH_FILL,
        PH_LEN
    } phase_e;

    typedef enum logic [1:0] {
        SRC_ACC,
        SRC_ZERO,
        SRC_LEN
    } wsrc_e;

endpackage

// File: rtl/kpk_accum.sv
module kpk_accum #(
    parameter int WORD_BYTES = 4,
    parameter int ACC_BYTES  = 8
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              clr,
    input  logic                              push_en,
    input  logic [$clog2(ACC_BYTES+1)-1:0]    push_len,
    input  logic [8*ACC_BYTES-1:0]            push_data,
    input  logic                              pop,
    input  logic                              pad,
    output logic [8*WORD_BYTES-1:0]           head,
    output logic [$clog2(ACC_BYTES+1)-1:0]    cnt
);
    localparam int ACC_W  = 8 * ACC_BYTES;
    localparam int WORD_W = 8 * WORD_BYTES;
    localparam int CNT_W  = $clog2(ACC_BYTES + 1);

    typedef struct packed {
        logic [ACC_W-1:0] acc;
        logic [CNT_W-1:0] cnt;
    } acc_s;

    acc_s s_d, s_q;

    // Bytes are kept oldest-first from the MSB; unused low bytes stay zero.
    always_comb begin
        s_d = s_q;
        if (clr) begin
            s_d.acc = '0;
            s_d.cnt = '0;
        end else if (pop) begin
            s_d.acc = s_q.acc << WORD_W;
            s_d.cnt = s_q.cnt - CNT_W'(WORD_BYTES);
        end else if (pad) begin
            s_d.cnt = CNT_W'(WORD_BYTES);
        end else if (push_en) begin
            s_d.acc = s_q.acc | (push_data >> {s_q.cnt, 3'b000});
            s_d.cnt = s_q.cnt + push_len;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign head = s_q.acc[ACC_W-1 -: WORD_W];
    assign cnt  = s_q.cnt;

    // R2: a push never overruns the byte store
    p_no_overflow_r2: assert property (@(posedge clk) disable iff (!rst_n)
        push_en |-> (32'(s_q.cnt) + 32'(push_len) <= ACC_BYTES));

    // R2: a word leaves only when four bytes are held
    p_pop_full_r2: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> (32'(s_q.cnt) >= WORD_BYTES));

    // R3: zero fill only tops up a partial word
    p_pad_partial_r3: assert property (@(posedge clk) disable iff (!rst_n)
        pad |-> (s_q.cnt != '0) && (32'(s_q.cnt) < WORD_BYTES));

endmodule

// File: rtl/kpk_tail.sv
module kpk_tail #(
    parameter int WORD_BYTES  = 4,
    parameter int BLOCK_BYTES = 64,
    parameter int DEV_W       = 7,
    parameter int KEY_BYTES   = 5,
    parameter int TRAIL_BYTES = 10
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     clr,
    input  logic [DEV_W-1:0]         dev_count,
    input  logic                     advance,
    input  logic                     last_i,
    output logic                     off_at_end,
    output logic [8*WORD_BYTES-1:0]  len_word
);
    localparam int WORD_W = 8 * WORD_BYTES;
    localparam int OFF_W  = $clog2(BLOCK_BYTES);

    typedef struct packed {
        logic [OFF_W-1:0] off;
        logic [DEV_W-1:0] n;
    } tail_s;

    tail_s s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (clr) begin
            s_d.off = '0;
            s_d.n   = dev_count;
        end else if (advance) begin
            s_d.off = s_q.off + OFF_W'(WORD_BYTES);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign off_at_end = (s_q.off == OFF_W'(BLOCK_BYTES - WORD_BYTES));
    assign len_word   = (WORD_W'(s_q.n) * WORD_W'(KEY_BYTES) + WORD_W'(TRAIL_BYTES)) << 3;

    // R4: the length word lands in the last slot of a block
    p_len_slot_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (advance && last_i) |-> off_at_end);

    // R4: the offset stays word aligned
    p_off_aligned_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (32'(s_q.off) % WORD_BYTES) == 0);

endmodule

// File: rtl/kpk_seq.sv
module kpk_seq
    import kpk_pkg::*;
#(
    parameter int DEV_W      = 7,
    parameter int KEY_BYTES  = 5,
    parameter int STAT_BYTES = 2,
    parameter int SEC_BYTES  = 8,
    parameter int WORD_BYTES = 4,
    parameter int ACC_BYTES  = 8
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            start,
    input  logic [DEV_W-1:0]                dev_count,
    input  logic [8*STAT_BYTES-1:0]         status,
    input  logic [8*SEC_BYTES-1:0]          m0,
    input  logic                            key_valid,
    input  logic [8*KEY_BYTES-1:0]          key_data,
    output logic                            key_ready,
    input  logic                            word_ready,
    input  logic [$clog2(ACC_BYTES+1)-1:0]  acc_cnt,
    input  logic                            off_at_end,
    output logic                            clr,
    output logic                            push_en,
    output logic [$clog2(ACC_BYTES+1)-1:0]  push_len,
    output logic [8*ACC_BYTES-1:0]          push_data,
    output logic                            pop,
    output logic                            pad,
    output logic                            word_valid,
    output wsrc_e                           word_src,
    output logic                            word_last,
    output logic                            done,
    output logic                            err
);
    localparam int KEY_W   = 8 * KEY_BYTES;
    localparam int STAT_W  = 8 * STAT_BYTES;
    localparam int SEC_W   = 8 * SEC_BYTES;
    localparam int WORD_W  = 8 * WORD_BYTES;
    localparam int ACC_W   = 8 * ACC_BYTES;
    localparam int ACNT_W  = $clog2(ACC_BYTES + 1);
    localparam int CHUNKS  = SEC_BYTES / WORD_BYTES;
    localparam int CH_W    = $clog2(CHUNKS + 1);

    typedef struct packed {
        phase_e             phase;
        logic [DEV_W-1:0]   left;
        logic [STAT_W-1:0]  stat;
        logic [SEC_W-1:0]   sec;
        logic [CH_W-1:0]    chunks;
        logic               done;
        logic               err;
    } seq_s;

    seq_s s_d, s_q;
    logic full;
    logic packing;

    always_comb begin
        s_d        = s_q;
        s_d.done   = 1'b0;
        s_d.err    = 1'b0;
        key_ready  = 1'b0;
        clr        = 1'b0;
        push_en    = 1'b0;
        push_len   = '0;
        push_data  = '0;
        pop        = 1'b0;
        pad        = 1'b0;
        word_valid = 1'b0;
        word_src   = SRC_ACC;
        word_last  = 1'b0;
        full       = (acc_cnt >= ACNT_W'(WORD_BYTES));
        packing    = s_q.phase inside {PH_KEYS, PH_STAT, PH_SECRET, PH_FLUSH};

        unique case (s_q.phase)
            PH_IDLE: begin
                if (start) begin
                    if (dev_count == '0) begin
                        s_d.err = 1'b1;
                    end else begin
                        clr        = 1'b1;
                        s_d.phase  = PH_KEYS;
                        s_d.left   = dev_count;
                        s_d.stat   = status;
                        s_d.sec    = m0;
                        s_d.chunks = CH_W'(CHUNKS);
                    end
                end
            end
            PH_KEYS: begin
                if (!full) begin
                    key_ready = 1'b1;
                    if (key_valid) begin
                        push_en   = 1'b1;
                        push_len  = ACNT_W'(KEY_BYTES);
                        push_data = {key_data, {(ACC_W-KEY_W){1'b0}}};
                        s_d.left  = s_q.left - DEV_W'(1);
                        if (s_q.left == DEV_W'(1)) s_d.phase = PH_STAT;
                    end
                end
            end
            PH_STAT: begin
                if (!full) begin
                    push_en   = 1'b1;
                    push_len  = ACNT_W'(STAT_BYTES);
                    push_data = {s_q.stat, {(ACC_W-STAT_W){1'b0}}};
                    s_d.phase = PH_SECRET;
                end
            end
            PH_SECRET: begin
                if (!full) begin
                    push_en    = 1'b1;
                    push_len   = ACNT_W'(WORD_BYTES);
                    push_data  = {s_q.sec[SEC_W-1 -: WORD_W], {(ACC_W-WORD_W){1'b0}}};
                    s_d.sec    = s_q.sec << WORD_W;
                    s_d.chunks = s_q.chunks - CH_W'(1);
                    if (s_q.chunks == CH_W'(1)) s_d.phase = PH_FLUSH;
                end
            end
            PH_FLUSH: begin
                if (!full) begin
                    if (acc_cnt == '0) s_d.phase = PH_FILL;
                    else               pad = 1'b1;
                end
            end
            PH_FILL: begin
                if (off_at_end) begin
                    s_d.phase = PH_LEN;
                end else begin
                    word_valid = 1'b1;
                    word_src   = SRC_ZERO;
                end
            end
            PH_LEN: begin
                word_valid = 1'b1;
                word_src   = SRC_LEN;
                word_last  = 1'b1;
                if (word_ready) begin
                    s_d.phase = PH_IDLE;
                    s_d.done  = 1'b1;
                end
            end
            default: s_d.phase = PH_IDLE;
        endcase

        if (packing && full) begin
            word_valid = 1'b1;
            word_src   = SRC_ACC;
            pop        = word_ready;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q       <= '0;
            s_q.phase <= PH_IDLE;
        end else begin
            s_q <= s_d;
        end
    end

    assign done = s_q.done;
    assign err  = s_q.err;

    // R8: done is a single-cycle pulse and the block goes quiet after it
    p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done && !word_valid);

    // R9: err is a single-cycle pulse
    p_err_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        err |=> !err);

    // R10: a start during a message does not restart the key count
    p_busy_start_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (start && s_q.phase != PH_IDLE && !key_ready) |=> $stable(s_q.left));

endmodule

// File: rtl/keylist_hash_packer.sv
module keylist_hash_packer
    import kpk_pkg::*;
#(
    parameter int DEV_W       = 7,
    parameter int KEY_BYTES   = 5,
    parameter int STAT_BYTES  = 2,
    parameter int SEC_BYTES   = 8,
    parameter int WORD_BYTES  = 4,
    parameter int BLOCK_BYTES = 64
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         start,
    input  logic [DEV_W-1:0]             dev_count,
    input  logic [8*STAT_BYTES-1:0]      status,
    input  logic [8*SEC_BYTES-1:0]       m0,
    input  logic                         key_valid,
    input  logic [8*KEY_BYTES-1:0]       key_data,
    output logic                         key_ready,
    output logic                         word_valid,
    output logic [8*WORD_BYTES-1:0]      word_data,
    output logic                         word_last,
    input  logic                         word_ready,
    output logic                         done,
    output logic                         err
);
    localparam int ACC_BYTES   = WORD_BYTES - 1 + KEY_BYTES;
    localparam int ACC_W       = 8 * ACC_BYTES;
    localparam int ACNT_W      = $clog2(ACC_BYTES + 1);
    localparam int WORD_W      = 8 * WORD_BYTES;
    localparam int TRAIL_BYTES = STAT_BYTES + SEC_BYTES;

    logic              clr, push_en, pop, pad, off_at_end, advance;
    logic [ACNT_W-1:0] push_len, acc_cnt;
    logic [ACC_W-1:0]  push_data;
    logic [WORD_W-1:0] head, len_word;
    wsrc_e             word_src;

    kpk_seq #(
        .DEV_W(DEV_W), .KEY_BYTES(KEY_BYTES), .STAT_BYTES(STAT_BYTES),
        .SEC_BYTES(SEC_BYTES), .WORD_BYTES(WORD_BYTES), .ACC_BYTES(ACC_BYTES)
    ) u_seq (
        .clk(clk), .rst_n(rst_n), .start(start), .dev_count(dev_count),
        .status(status), .m0(m0), .key_valid(key_valid), .key_data(key_data),
        .key_ready(key_ready), .word_ready(word_ready), .acc_cnt(acc_cnt),
        .off_at_end(off_at_end), .clr(clr), .push_en(push_en),
        .push_len(push_len), .push_data(push_data), .pop(pop), .pad(pad),
        .word_valid(word_valid), .word_src(word_src), .word_last(word_last),
        .done(done), .err(err)
    );

    kpk_accum #(.WORD_BYTES(WORD_BYTES), .ACC_BYTES(ACC_BYTES)) u_acc (
        .clk(clk), .rst_n(rst_n), .clr(clr), .push_en(push_en),
        .push_len(push_len), .push_data(push_data), .pop(pop), .pad(pad),
        .head(head), .cnt(acc_cnt)
    );

    assign advance = word_valid && word_ready;

    kpk_tail #(
        .WORD_BYTES(WORD_BYTES), .BLOCK_BYTES(BLOCK_BYTES), .DEV_W(DEV_W),
        .KEY_BYTES(KEY_BYTES), .TRAIL_BYTES(TRAIL_BYTES)
    ) u_tail (
        .clk(clk), .rst_n(rst_n), .clr(clr), .dev_count(dev_count),
        .advance(advance), .last_i(word_last), .off_at_end(off_at_end),
        .len_word(len_word)
    );

    always_comb begin
        unique case (word_src)
            SRC_ACC:  word_data = head;
            SRC_ZERO: word_data = '0;
            SRC_LEN:  word_data = len_word;
            default:  word_data = '0;
        endcase
    end

    // R7: an offered word is held until taken
    p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (word_valid && !word_ready) |=> word_valid && $stable(word_data) && $stable(word_last));

    // R11: an accepted key lands whole in the byte store
    p_key_lands_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (key_valid && key_ready) |=> (32'(acc_cnt) >= KEY_BYTES));

endmodule

// File: tb/keylist_hash_packer_test.sv
`timescale 1ns/1ps
module keylist_hash_packer_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [6:0]  dev_count = '0;
    logic [15:0] status = '0;
    logic [63:0] m0 = '0;
    logic        key_valid = 1'b0;
    logic [39:0] key_data = '0;
    logic        key_ready;
    logic        word_valid;
    logic [31:0] word_data;
    logic        word_last;
    logic        word_ready = 1'b0;
    logic        done;
    logic        err;

    int tests = 0;
    int fails = 0;
    bit finished = 1'b0;

    logic [39:0] keys [0:127];
    int          n_cur;
    logic [15:0] stat_cur;
    logic [63:0] sec_cur;

    always #2.5 clk = ~clk;

    keylist_hash_packer uut (
        .clk(clk), .rst_n(rst_n), .start(start), .dev_count(dev_count),
        .status(status), .m0(m0), .key_valid(key_valid), .key_data(key_data),
        .key_ready(key_ready), .word_valid(word_valid), .word_data(word_data),
        .word_last(word_last), .word_ready(word_ready), .done(done), .err(err)
    );

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] msg_byte(input int b);
        int kb = 5 * n_cur;
        if (b < kb) begin
            logic [39:0] k = keys[b / 5];
            return k[39 - 8 * (b % 5) -: 8];
        end else if (b < kb + 2) begin
            return stat_cur[15 - 8 * (b - kb) -: 8];
        end else if (b < kb + 10) begin
            return sec_cur[63 - 8 * (b - kb - 2) -: 8];
        end
        return 8'h00;
    endfunction

    function automatic int total_words();
        int p = ((5 * n_cur + 10 + 3) / 4) * 4;
        int t = ((p + 4 + 63) / 64) * 64;
        return t / 4;
    endfunction

    function automatic logic [31:0] exp_word(input int w);
        logic [31:0] v = '0;
        if (w == total_words() - 1) return 32'((5 * n_cur + 10) * 8);
        for (int i = 0; i < 4; i++) v[31 - 8 * i -: 8] = msg_byte(4 * w + i);
        return v;
    endfunction

    function automatic string word_req(input int w);
        int mlen = 5 * n_cur + 10;
        if (w == total_words() - 1) return "R5";
        if (4 * w >= mlen) return "R4";
        if (4 * w + 4 > mlen) return "R3";
        if (4 * w + 4 > 5 * n_cur) return "R2";
        return "R1";
    endfunction

    function automatic bit rdy_pat(input int c, input int mode);
        case (mode)
            1: return (c % 3) != 1;
            2: return (c % 5) < 2;
            default: return 1'b1;
        endcase
    endfunction

    // One full message: count n, output backpressure mode, key gaps, optional mid-run start
    task automatic run_case(input int n, input int mode, input bit gaps, input bit restart, input int seed);
        int widx = 0;
        int kidx = 0;
        bit got_last = 1'b0;
        bit prev_stall = 1'b0;
        logic [31:0] prev_data = '0;
        int tw;
        n_cur = n;
        stat_cur = 16'(seed * 16'h1357 + 16'h0A0B);
        sec_cur = 64'hC0FFEE00_12345678 ^ 64'(seed * 64'h0101_0101_0101);
        for (int i = 0; i < 128; i++) keys[i] = 40'(64'(i + seed) * 64'h9E_3779_B97F + 64'h55);
        tw = total_words();
        @(negedge clk);
        start = 1'b1; dev_count = 7'(n); status = stat_cur; m0 = sec_cur;
        @(negedge clk);
        start = 1'b0; status = '1; m0 = '1;
        for (int c = 0; c < 5000 && !got_last; c++) begin
            @(negedge clk);
            start = 1'b0;
            if (restart && c == 5) begin
                start = 1'b1; dev_count = 7'd3;
            end
            if (prev_stall)
                chk(word_valid && word_data == prev_data, "R7 hold", {31'b0, word_valid, word_data}, {31'b0, 1'b1, prev_data});
            word_ready = rdy_pat(c, mode);
            if (word_valid && word_ready) begin
                logic [31:0] e = exp_word(widx);
                chk(word_data == e, word_req(widx), word_data, e);
                chk(word_last == (widx == tw - 1), "R6", word_last, (widx == tw - 1));
                if (word_last) got_last = 1'b1;
                widx++;
            end
            prev_stall = word_valid && !word_ready;
            prev_data  = word_data;
            if (key_ready && kidx >= n)
                chk(1'b0, "R11 extra key request", kidx, n);
            key_valid = (kidx < n) && (!gaps || (c % 3) != 0);
            key_data  = keys[kidx < 128 ? kidx : 0];
            if (key_valid && key_ready) kidx++;
        end
        chk(got_last, "R12 message completes", got_last, 1);
        @(negedge clk);
        start = 1'b0; key_valid = 1'b0; word_ready = 1'b0;
        chk(done == 1'b1, "R8 done pulse", done, 1);
        @(negedge clk);
        chk(done == 1'b0 && word_valid == 1'b0 && key_ready == 1'b0, "R8 idle after done",
            {done, word_valid, key_ready}, 0);
        chk(widx == tw, "R4 word count", widx, tw);
        chk(kidx == n, "R11 key count", kidx, n);
    endtask

    task automatic zero_count_case();
        @(negedge clk);
        start = 1'b1; dev_count = 7'd0;
        @(negedge clk);
        start = 1'b0;
        chk(err == 1'b1, "R9 err pulse", err, 1);
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            chk(err == 1'b0 && word_valid == 1'b0 && key_ready == 1'b0, "R9 no output",
                {err, word_valid, key_ready}, 0);
        end
    endtask

    task automatic reset_case();
        @(negedge clk);
        chk(word_valid == 1'b0 && key_ready == 1'b0 && done == 1'b0 && err == 1'b0,
            "R8 reset state", {word_valid, key_ready, done, err}, 0);
    endtask

    initial begin
        #(200000 * 5);
        if (!finished) begin
            fails++;
            tests++;
            $display("FAIL watchdog expired");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        reset_case();
        run_case(1, 0, 1'b0, 1'b0, 1);    // R1 R2: one leftover byte
        run_case(2, 1, 1'b0, 1'b0, 2);    // R2: two leftover bytes
        run_case(3, 2, 1'b1, 1'b0, 3);    // R2 R3 R7: three leftover, stalls, key gaps
        run_case(4, 0, 1'b1, 1'b0, 4);    // R2: aligned, no leftover
        zero_count_case();                // R9
        run_case(10, 1, 1'b0, 1'b0, 5);   // R4: data ends at offset 60
        run_case(23, 2, 1'b0, 1'b0, 6);   // R4: data ends on a block edge
        run_case(5, 1, 1'b1, 1'b1, 7);    // R10: start during a message
        run_case(127, 1, 1'b1, 1'b0, 8);  // R12: largest count
        finished = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule